// File: doc/BRIEF.md
# Disk Interface Task-File Register Block

This block is the device-side register file of an AT-style parallel disk interface. The host selects it with two chip selects, a command-block select and a control-block select, and a 3-bit address. The host then reads or writes single bytes. The block decodes each access and holds the features, sector count, sector number, cylinder low and high, and drive/head parameters. It also holds the error, status and device control state. It drives the interrupt request line.

An internal command engine sees the parameter values, the command code and a command-request level on dedicated outputs. It acknowledges a command with a strobe. It reports progress by loading whole status or error bytes and by pulsing an interrupt-set input.

Several host-side rules are enforced in the block itself:
- While the busy bit is set, command-block reads return status.
- While the busy bit is set, parameter writes are dropped.
- A status read clears the pending interrupt.
- A software-reset bit in the write-only control register holds the block in its reset state.

Top module: `tf_regblock`

## Requirements
- R1: With only the command-block select active, address 1 reads the error register and writes features. Addresses 2 to 6 read and write, in turn, sector count, sector number, cylinder low, cylinder high and drive/head. Address 7 reads status and writes the command. With only the control-block select active, address 6 reads the alternate status and writes device control.
- R2: After hardware reset the register values are as follows:
  - sector count and sector number are 01h;
  - features, cylinders, drive/head and error are 00h;
  - status is 40h (ready);
  - the interrupt, the command request and the soft-reset output are low.
- R3: A read that decodes to no register returns FFh, and a write to it changes nothing. Such accesses are: address 0 of the command block, any control-block address other than 6, both selects active, or no select active.
- R4: A command write has these effects from the next cycle:
  - status bit 7 (busy) is set;
  - the command code output holds the written byte;
  - the command request stays high until a command-acknowledge strobe.
- R5: While status bit 7 is 1, a read of any command-block address from 1 to 7 returns the status byte.
- R6: While status bit 7 is 1, host writes to command-block addresses 1 to 6 are ignored.
- R7: The engine loads the whole status byte and the whole error byte with its write strobes. Status bit 7 down to bit 0 are: busy, ready, write fault, seek complete, data request, corrected, index, error. Error bit 7 down to bit 0 are: bad block, uncorrectable, 0, ID not found, 0, aborted, track 0 not found, address mark not found.
- R8: The alternate status read returns the same byte as status and does not clear a pending interrupt.
- R9: The interrupt output is high only when all three hold: an interrupt is pending, drive/head bit 4 equals the DEV_ID parameter, and device control bit 1 (interrupt disable) is 0.
- R10: An engine interrupt-set pulse makes the interrupt pending. A status read at address 7 with the read strobe, or a command write, clears it. A set wins over a clear in the same cycle.
- R11: Device control bit 2 (soft reset) holds the block in reset from the cycle after it is written:
  - status reads 80h;
  - parameter registers return to their reset values;
  - the pending interrupt and the command request are cleared;
  - command writes and engine status loads are ignored;
  - the soft-reset output is high.
- R12: The 28-bit block address output packs the fields from low to high: sector number in bits 0-7, cylinder low in bits 8-15, cylinder high in bits 16-23, drive/head bits 3:0 in bits 24-27. The address-mode output is drive/head bit 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low hardware reset |
| cs_cmd_i | input | 1 | Command-block select |
| cs_ctl_i | input | 1 | Control-block select |
| addr_i | input | 3 | Register address |
| wr_i | input | 1 | Host write strobe, one cycle |
| rd_i | input | 1 | Host read strobe, one cycle (side effects only) |
| wdata_i | input | 8 | Host write data |
| rdata_o | output | 8 | Read data for the current select and address |
| irq_o | output | 1 | Interrupt request |
| cmd_req_o | output | 1 | Command waiting for the engine |
| cmd_code_o | output | 8 | Last command code written |
| cmd_ack_i | input | 1 | Engine accepts the command |
| eng_stat_we_i | input | 1 | Engine status load strobe |
| eng_stat_i | input | 8 | Engine status byte |
| eng_err_we_i | input | 1 | Engine error load strobe |
| eng_err_i | input | 8 | Engine error byte |
| eng_irq_i | input | 1 | Engine interrupt-set pulse |
| feat_o | output | 8 | Features value |
| scnt_o | output | 8 | Sector count value |
| snum_o | output | 8 | Sector number value |
| cyl_o | output | 16 | Cylinder high and low |
| head_o | output | 4 | Drive/head bits 3:0 |
| lba_mode_o | output | 1 | Drive/head bit 6 |
| lba_o | output | 28 | Packed block address |
| soft_rst_o | output | 1 | Software reset active |

## Verification
The decoder is swept over all 32 combinations of the two selects and the address. Each read is compared with a bench model, which separates the mapped registers from the unmapped ones and the command block from the control block. The same sweep runs in the idle state and in the busy state. The idle pass shows each register's own value; the busy pass shows the status substitution.

The interrupt output is toggled through each of its gating terms in turn: pending, drive select and disable bit. It is cleared through each path: status read, command write and soft reset. The alternate-status read serves as the non-clearing control case.

Writes made while busy and during soft reset are then read back at the ports to show they were dropped.

// File: rtl/tf_pkg.sv
package tf_pkg;
  parameter int TF_DW = 8;
  parameter int TF_AW = 3;
  parameter int TF_NPAR = 6;
  localparam int TF_LBAW = 4 * TF_DW - 4;

  // parameter register slots
  localparam int P_FEAT = 0;
  localparam int P_SCNT = 1;
  localparam int P_SNUM = 2;
  localparam int P_CYLL = 3;
  localparam int P_CYLH = 4;
  localparam int P_DRVH = 5;

  localparam int ST_BUSY = 7;
  localparam logic [TF_DW-1:0] ST_RESET = 8'h40;
  localparam logic [TF_DW-1:0] ST_SRST  = 8'h80;

  typedef enum logic [3:0] {
    RG_NONE, RG_ERRFEAT, RG_SCNT, RG_SNUM, RG_CYLL,
    RG_CYLH, RG_DRVH, RG_STATCMD, RG_ALTCTL
  } tf_reg_e;

  function automatic tf_reg_e tf_decode(input logic cs_cmd, input logic cs_ctl,
                                        input logic [TF_AW-1:0] a);
    tf_reg_e r;
    r = RG_NONE;
    if (cs_cmd && !cs_ctl) begin
      case (a)
        3'd1: r = RG_ERRFEAT;
        3'd2: r = RG_SCNT;
        3'd3: r = RG_SNUM;
        3'd4: r = RG_CYLL;
        3'd5: r = RG_CYLH;
        3'd6: r = RG_DRVH;
        3'd7: r = RG_STATCMD;
        default: r = RG_NONE;
      endcase
    end else if (cs_ctl && !cs_cmd && a == 3'd6) begin
      r = RG_ALTCTL;
    end
    return r;
  endfunction

  function automatic tf_reg_e tf_par_reg(input int idx);
    case (idx)
      P_FEAT: return RG_ERRFEAT;
      P_SCNT: return RG_SCNT;
      P_SNUM: return RG_SNUM;
      P_CYLL: return RG_CYLL;
      P_CYLH: return RG_CYLH;
      default: return RG_DRVH;
    endcase
  endfunction

  function automatic logic [TF_DW-1:0] tf_par_rst(input int idx);
    return (idx == P_SCNT || idx == P_SNUM) ? 8'h01 : 8'h00;
  endfunction

  function automatic logic tf_is_cmdblk(input tf_reg_e r);
    return (r != RG_NONE) && (r != RG_ALTCTL);
  endfunction

  function automatic logic [TF_LBAW-1:0] tf_lba(input logic [TF_DW-1:0] snum,
      input logic [TF_DW-1:0] cyll, input logic [TF_DW-1:0] cylh,
      input logic [3:0] hd);
    return {hd, cylh, cyll, snum};
  endfunction
endpackage

// File: rtl/tf_addr_dec.sv
module tf_addr_dec
  import tf_pkg::*;
(
  input  logic                 cs_cmd,
  input  logic                 cs_ctl,
  input  logic [TF_AW-1:0]     addr,
  input  logic                 wr,
  input  logic                 rd,
  input  logic                 busy,
  input  logic                 srst,
  output tf_reg_e              rsel,
  output logic [TF_NPAR-1:0]   pwe,
  output logic                 cmd_we,
  output logic                 ctl_we,
  output logic                 stat_rd
);
  assign rsel = tf_decode(cs_cmd, cs_ctl, addr);

  // parameter writes are dropped while busy or in soft reset
  for (genvar i = 0; i < TF_NPAR; i++) begin : g_pwe
    assign pwe[i] = wr && !busy && !srst && (rsel == tf_par_reg(i));
  end

  assign cmd_we  = wr && !srst && (rsel == RG_STATCMD);
  assign ctl_we  = wr && (rsel == RG_ALTCTL);
  assign stat_rd = rd && (rsel == RG_STATCMD);
endmodule

// File: rtl/tf_param_regs.sv
module tf_param_regs
  import tf_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           clr,
  input  logic [TF_NPAR-1:0]             we,
  input  logic [TF_DW-1:0]               wdata,
  output logic [TF_NPAR-1:0][TF_DW-1:0]  q
);
  for (genvar i = 0; i < TF_NPAR; i++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= tf_par_rst(i);
      else if (clr)    q[i] <= tf_par_rst(i);
      else if (we[i])  q[i] <= wdata;
    end
  end
endmodule

// File: rtl/tf_stat_ctl.sv
module tf_stat_ctl
  import tf_pkg::*;
#(
  parameter logic DEV_ID = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_we,
  input  logic              ctl_we,
  input  logic              stat_rd,
  input  logic [TF_DW-1:0]  wdata,
  input  logic              drv_bit,
  input  logic              cmd_ack,
  input  logic              eng_stat_we,
  input  logic [TF_DW-1:0]  eng_stat,
  input  logic              eng_err_we,
  input  logic [TF_DW-1:0]  eng_err,
  input  logic              eng_irq,
  output logic [TF_DW-1:0]  stat,
  output logic [TF_DW-1:0]  err,
  output logic              pend,
  output logic              srst,
  output logic              nien,
  output logic              sel,
  output logic              irq,
  output logic [TF_DW-1:0]  cmd_code,
  output logic              cmd_req
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      srst <= 1'b0;
      nien <= 1'b0;
    end else if (ctl_we) begin
      srst <= wdata[2];
      nien <= wdata[1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stat     <= ST_RESET;
      err      <= '0;
      pend     <= 1'b0;
      cmd_code <= '0;
      cmd_req  <= 1'b0;
    end else if (srst) begin
      stat    <= ST_SRST;
      pend    <= 1'b0;
      cmd_req <= 1'b0;
    end else begin
      if (cmd_we) begin
        stat     <= stat | (TF_DW'(1) << ST_BUSY);
        cmd_code <= wdata;
        cmd_req  <= 1'b1;
      end else begin
        if (eng_stat_we) stat <= eng_stat;
        if (cmd_ack)     cmd_req <= 1'b0;
      end
      if (eng_err_we) err <= eng_err;
      if (eng_irq)                 pend <= 1'b1;
      else if (stat_rd || cmd_we)  pend <= 1'b0;
    end
  end

  assign sel = (drv_bit == DEV_ID);
  assign irq = pend && sel && !nien;
endmodule

// File: rtl/tf_regblock.sv
module tf_regblock
  import tf_pkg::*;
#(
  parameter logic DEV_ID = 1'b0
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cs_cmd_i,
  input  logic                cs_ctl_i,
  input  logic [TF_AW-1:0]    addr_i,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [TF_DW-1:0]    wdata_i,
  output logic [TF_DW-1:0]    rdata_o,
  output logic                irq_o,
  output logic                cmd_req_o,
  output logic [TF_DW-1:0]    cmd_code_o,
  input  logic                cmd_ack_i,
  input  logic                eng_stat_we_i,
  input  logic [TF_DW-1:0]    eng_stat_i,
  input  logic                eng_err_we_i,
  input  logic [TF_DW-1:0]    eng_err_i,
  input  logic                eng_irq_i,
  output logic [TF_DW-1:0]    feat_o,
  output logic [TF_DW-1:0]    scnt_o,
  output logic [TF_DW-1:0]    snum_o,
  output logic [2*TF_DW-1:0]  cyl_o,
  output logic [3:0]          head_o,
  output logic                lba_mode_o,
  output logic [TF_LBAW-1:0]  lba_o,
  output logic                soft_rst_o
);
  tf_reg_e                          rsel;
  logic [TF_NPAR-1:0]               pwe;
  logic                             cmd_we, ctl_we, stat_rd;
  logic [TF_NPAR-1:0][TF_DW-1:0]    par_q;
  logic [TF_DW-1:0]                 stat, err;
  logic                             pend, srst, nien, sel, busy;
  logic [TF_DW-1:0]                 reg_val;

  assign busy = stat[ST_BUSY];

  tf_addr_dec u_dec (
    .cs_cmd(cs_cmd_i), .cs_ctl(cs_ctl_i), .addr(addr_i), .wr(wr_i), .rd(rd_i),
    .busy(busy), .srst(srst), .rsel(rsel), .pwe(pwe), .cmd_we(cmd_we),
    .ctl_we(ctl_we), .stat_rd(stat_rd)
  );

  tf_param_regs u_par (
    .clk(clk), .rst_n(rst_n), .clr(srst), .we(pwe), .wdata(wdata_i), .q(par_q)
  );

  tf_stat_ctl #(.DEV_ID(DEV_ID)) u_sc (
    .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .ctl_we(ctl_we),
    .stat_rd(stat_rd), .wdata(wdata_i), .drv_bit(par_q[P_DRVH][4]),
    .cmd_ack(cmd_ack_i), .eng_stat_we(eng_stat_we_i), .eng_stat(eng_stat_i),
    .eng_err_we(eng_err_we_i), .eng_err(eng_err_i), .eng_irq(eng_irq_i),
    .stat(stat), .err(err), .pend(pend), .srst(srst), .nien(nien), .sel(sel),
    .irq(irq_o), .cmd_code(cmd_code_o), .cmd_req(cmd_req_o)
  );

  always_comb begin
    case (rsel)
      RG_ERRFEAT: reg_val = err;
      RG_SCNT:    reg_val = par_q[P_SCNT];
      RG_SNUM:    reg_val = par_q[P_SNUM];
      RG_CYLL:    reg_val = par_q[P_CYLL];
      RG_CYLH:    reg_val = par_q[P_CYLH];
      RG_DRVH:    reg_val = par_q[P_DRVH];
      RG_STATCMD: reg_val = stat;
      RG_ALTCTL:  reg_val = stat;
      default:    reg_val = '1;
    endcase
  end

  assign rdata_o    = (busy && tf_is_cmdblk(rsel)) ? stat : reg_val;
  assign feat_o     = par_q[P_FEAT];
  assign scnt_o     = par_q[P_SCNT];
  assign snum_o     = par_q[P_SNUM];
  assign cyl_o      = {par_q[P_CYLH], par_q[P_CYLL]};
  assign head_o     = par_q[P_DRVH][3:0];
  assign lba_mode_o = par_q[P_DRVH][6];
  assign lba_o      = tf_lba(par_q[P_SNUM], par_q[P_CYLL], par_q[P_CYLH],
                             par_q[P_DRVH][3:0]);
  assign soft_rst_o = srst;
endmodule

// File: rtl/tf_regblock_chk.sv
module tf_regblock_chk
  import tf_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              cs_cmd,
  input logic              cs_ctl,
  input logic [TF_AW-1:0]  addr,
  input logic              wr,
  input logic [TF_DW-1:0]  rdata,
  input logic [TF_DW-1:0]  stat,
  input logic              pend,
  input logic              sel,
  input logic              nien,
  input logic              srst,
  input logic              irq,
  input logic              cmd_we,
  input logic              stat_rd,
  input logic              eng_irq,
  input logic              cmd_req,
  input logic [TF_DW-1:0]  scnt
);
  // R3: no select at all reads as all ones
  a_r3_unmapped_ones: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_cmd && !cs_ctl) |-> rdata == 8'hFF);

  // R4: command write raises busy and the request
  a_r4_cmd_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_we && !srst) |=> (stat[7] && cmd_req));

  // R5: busy command-block reads return status
  a_r5_busy_reads_status: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[7] && cs_cmd && !cs_ctl && addr != 3'd0) |-> rdata == stat);

  // R6: busy writes to sector count are dropped
  a_r6_busy_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (stat[7] && !srst && wr && cs_cmd && !cs_ctl && addr == 3'd2) |=> $stable(scnt));

  // R8: alternate status mirrors status
  a_r8_alt_eq_status: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_ctl && !cs_cmd && addr == 3'd6) |-> rdata == stat);

  // R9: interrupt gating
  a_r9_irq_gated: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (pend && sel && !nien));

  // R10: status read clears the pending interrupt
  a_r10_status_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_rd && !eng_irq) |=> !pend);

  // R11: soft reset forces the busy-only status
  a_r11_srst_status: assert property (@(posedge clk) disable iff (!rst_n)
    srst |=> (stat == 8'h80 && !pend && !cmd_req));
endmodule

bind tf_regblock tf_regblock_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs_cmd(cs_cmd_i), .cs_ctl(cs_ctl_i), .addr(addr_i),
  .wr(wr_i), .rdata(rdata_o), .stat(stat), .pend(pend), .sel(sel), .nien(nien),
  .srst(srst), .irq(irq_o), .cmd_we(cmd_we), .stat_rd(stat_rd),
  .eng_irq(eng_irq_i), .cmd_req(cmd_req_o), .scnt(scnt_o)
);

// File: tb/sim_tf_regblock.sv
module sim_tf_regblock;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_cmd = 0, cs_ctl = 0, wr = 0, rd = 0, cmd_ack = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, eng_stat = 0, eng_err = 0;
  logic eng_stat_we = 0, eng_err_we = 0, eng_irq = 0;
  logic [7:0] rdata, cmd_code, feat, scnt, snum;
  logic [15:0] cyl;
  logic [3:0] head;
  logic [27:0] lba;
  logic irq, cmd_req, lba_mode, soft_rst;

  int n_chk = 0, n_fail = 0;
  // bench model
  logic [7:0] m_feat = 0, m_scnt = 1, m_snum = 1, m_cyll = 0, m_cylh = 0, m_drvh = 0;
  logic [7:0] m_stat = 8'h40, m_err = 0;

  always #10 clk = ~clk;

  tf_regblock u0 (
    .clk(clk), .rst_n(rst_n), .cs_cmd_i(cs_cmd), .cs_ctl_i(cs_ctl), .addr_i(addr),
    .wr_i(wr), .rd_i(rd), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .cmd_req_o(cmd_req), .cmd_code_o(cmd_code), .cmd_ack_i(cmd_ack),
    .eng_stat_we_i(eng_stat_we), .eng_stat_i(eng_stat), .eng_err_we_i(eng_err_we),
    .eng_err_i(eng_err), .eng_irq_i(eng_irq), .feat_o(feat), .scnt_o(scnt),
    .snum_o(snum), .cyl_o(cyl), .head_o(head), .lba_mode_o(lba_mode), .lba_o(lba),
    .soft_rst_o(soft_rst)
  );

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rd(input logic c, input logic t, input logic [2:0] a);
    logic [7:0] v;
    v = 8'hFF;
    if (c && !t) begin
      case (a)
        3'd1: v = m_err;
        3'd2: v = m_scnt;
        3'd3: v = m_snum;
        3'd4: v = m_cyll;
        3'd5: v = m_cylh;
        3'd6: v = m_drvh;
        3'd7: v = m_stat;
        default: v = 8'hFF;
      endcase
      if (m_stat[7] && a != 3'd0) v = m_stat;
    end else if (t && !c && a == 3'd6) v = m_stat;
    return v;
  endfunction

  task automatic hwrite(input logic c, input logic t, input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    cs_cmd = c; cs_ctl = t; addr = a; wdata = d; wr = 1;
    @(negedge clk);
    wr = 0; cs_cmd = 0; cs_ctl = 0;
  endtask

  task automatic hread(input logic c, input logic t, input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    cs_cmd = c; cs_ctl = t; addr = a; rd = 1;
    #2 d = rdata;
    @(negedge clk);
    rd = 0; cs_cmd = 0; cs_ctl = 0;
  endtask

  task automatic eng_status(input logic [7:0] s);
    @(negedge clk); eng_stat = s; eng_stat_we = 1;
    @(negedge clk); eng_stat_we = 0;
    m_stat = s;
  endtask

  task automatic pulse_irq();
    @(negedge clk); eng_irq = 1;
    @(negedge clk); eng_irq = 0;
  endtask

  task automatic sweep(input string tag);
    logic [7:0] d;
    for (int k = 0; k < 32; k++) begin
      hread(k[4], k[3], k[2:0], d);
      chk(d, exp_rd(k[4], k[3], k[2:0]), tag);
    end
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R2 reset values
    chk(scnt, 8'h01, "R2 scnt"); chk(snum, 8'h01, "R2 snum");
    chk(feat, 0, "R2 feat"); chk(cyl, 0, "R2 cyl"); chk(head, 0, "R2 head");
    chk({irq, cmd_req, soft_rst}, 0, "R2 outputs");
    hread(1, 0, 7, d); chk(d, 8'h40, "R2 status");

    // R1 R3 write every parameter, then sweep the decode space
    hwrite(1, 0, 1, 8'hA5); m_feat = 8'hA5;
    hwrite(1, 0, 2, 8'h3C); m_scnt = 8'h3C;
    hwrite(1, 0, 3, 8'h81); m_snum = 8'h81;
    hwrite(1, 0, 4, 8'h7E); m_cyll = 8'h7E;
    hwrite(1, 0, 5, 8'hC3); m_cylh = 8'hC3;
    hwrite(1, 0, 6, 8'hE5); m_drvh = 8'hE5;
    hwrite(1, 0, 0, 8'h11); hwrite(0, 1, 2, 8'h22); hwrite(1, 1, 6, 8'h33); // R3 no effect
    chk(feat, 8'hA5, "R1 features");
    sweep("R1 R3 idle sweep");
    // R12 packing
    chk(lba, 28'h5C37E81, "R12 lba");
    chk(lba_mode, 1'b1, "R12 mode");

    // R7 engine loads
    eng_status(8'h58);
    @(negedge clk); eng_err = 8'h14; eng_err_we = 1;
    @(negedge clk); eng_err_we = 0; m_err = 8'h14;
    hread(1, 0, 7, d); chk(d, 8'h58, "R7 status");
    hread(1, 0, 1, d); chk(d, 8'h14, "R7 error");

    // R4 R5 R6 command and busy
    hwrite(1, 0, 7, 8'h20); m_stat = 8'hD8;
    chk(cmd_req, 1, "R4 cmd_req"); chk(cmd_code, 8'h20, "R4 cmd_code");
    hread(1, 0, 2, d); chk(d, 8'hD8, "R5 busy read");
    sweep("R5 busy sweep");
    hwrite(1, 0, 2, 8'h99); hwrite(1, 0, 6, 8'h00);
    chk(scnt, 8'h3C, "R6 scnt kept"); chk(head, 4'h5, "R6 head kept");
    chk(cmd_req, 1, "R4 held");
    @(negedge clk); cmd_ack = 1; @(negedge clk); cmd_ack = 0;
    chk(cmd_req, 0, "R4 ack");
    eng_status(8'h50);
    hread(1, 0, 2, d); chk(d, 8'h3C, "R6 after busy");

    // R9 R10 R8 interrupt
    pulse_irq(); chk(irq, 1, "R10 set");
    hread(0, 1, 6, d); chk(d, 8'h50, "R8 alt");
    chk(irq, 1, "R8 alt no clear");
    hwrite(0, 1, 6, 8'h02); chk(irq, 0, "R9 disabled");
    hwrite(0, 1, 6, 8'h00); chk(irq, 1, "R9 enabled");
    hwrite(1, 0, 6, 8'hF5); m_drvh = 8'hF5; chk(irq, 0, "R9 other drive");
    hwrite(1, 0, 6, 8'hE5); m_drvh = 8'hE5; chk(irq, 1, "R9 selected");
    hread(1, 0, 7, d); chk(irq, 0, "R10 status read clears");
    pulse_irq(); chk(irq, 1, "R10 set again");
    hwrite(1, 0, 7, 8'hEC); chk(irq, 0, "R10 cmd clears");
    eng_status(8'h50);

    // R11 soft reset
    pulse_irq();
    hwrite(0, 1, 6, 8'h04);
    @(negedge clk);
    chk(soft_rst, 1, "R11 output");
    m_stat = 8'h80; m_feat = 0; m_scnt = 1; m_snum = 1; m_cyll = 0; m_cylh = 0; m_drvh = 0;
    chk(irq, 0, "R11 pend cleared");
    hread(1, 0, 7, d); chk(d, 8'h80, "R11 status");
    hread(1, 0, 1, d); chk(d, 8'h80, "R11 busy read");
    chk(scnt, 1, "R11 scnt"); chk(feat, 0, "R11 feat"); chk(cyl, 0, "R11 cyl");
    hwrite(1, 0, 2, 8'h77);
    hwrite(1, 0, 7, 8'h30);
    pulse_irq(); chk(irq, 0, "R11 irq held off");
    chk(cmd_req, 0, "R11 cmd ignored");
    eng_status(8'h50); m_stat = 8'h80;
    hwrite(0, 1, 6, 8'h00);
    @(negedge clk);
    chk(soft_rst, 0, "R11 released");
    hread(1, 0, 7, d); chk(d, 8'h80, "R11 status after");
    chk(scnt, 1, "R11 write ignored");
    eng_status(8'h50);
    sweep("R1 post reset sweep");

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule